// File: doc/BRIEF.md
# Segmented Memory Access Privilege Guard

This block sits between a processor's memory request port and on-chip memories: program flash and a shared data space that holds RAM and data EEPROM. Each request is classified twice. The fetch address of the instruction that makes the request gives the *source* segment. The request address gives the *target* segment. Both use the same three-tier model: the boot tier is most privileged, the secure tier is in the middle, and the general tier is least privileged. A fixed policy table then grants or denies the read, write/erase or jump. The table is steered by a security level for the secure tier, a write lock on boot flash, and per-tier entry-point enables.

Denied writes never reach memory, and denied reads return zero to the processor. The first denied request sets a sticky flag and records the source tier, access kind, address space and address. This record holds until a clear pulse arrives. Tier sizes, data-space windows and policy bits are sampled from configuration pins on every clock while reset is asserted, and are frozen once reset is released.

Top module: `seg_guard`

## Requirements
- R1: A flash page (address bits above the page offset) below the boot page count is in the boot tier. A page below boot count plus secure count is in the secure tier. Any other page is general. The source tier is found by applying this map to `fetch_pc`.
- R2: Flash reads, writes and jumps to a general target, and data-space reads and writes to a general target, are granted from every source (R5 and R9 excepted).
- R3: A source may read, write and jump within its own tier, subject to R5.
- R4: With the secure level at standard (`cfg_sec_high`=0), boot code has full read, write and jump access to secure flash and secure data.
- R5: With `cfg_boot_wlock`=1, every flash write to a boot-tier page is denied, including writes from boot code.
- R6: With the secure level at high, boot code is denied reads and writes to secure flash and secure data. A jump into secure flash is granted only when `cfg_sec_entry`=1.
- R7: Secure code targeting boot flash or boot data gets full access at the high level. At standard level it may only jump into boot flash, and only when `cfg_boot_entry`=1.
- R8: General code may enter boot or secure flash only by a jump, and only when that tier's entry bit is set. Every other access it makes to those tiers is denied.
- R9: In the data space (`req_data`=1), a page in [boot lo, boot hi) is boot; otherwise a page in [secure lo, secure hi) is secure; otherwise it is general. A jump (`req_acc`=2) into the data space is always denied. An access code of 3 is always denied. Access codes: 0 read, 1 write, 2 jump.
- R10: `req_gnt`, `mem_re` and `mem_we` are combinational. `mem_re` and `mem_we` assert only for granted reads and granted writes. In the cycle after a request, `cpu_rdata` equals `mem_rdata` if that request was a granted read, and zero otherwise.
- R11: A denied valid request sets `viol` on the next clock and records source tier (0 general, 1 secure, 2 boot), access code, space and address. While `viol` is set, later denials do not overwrite the record. `viol_clr` clears the flag, but a denial in the same cycle as `viol_clr` wins and is recorded.
- R12: Configuration inputs are captured on every clock while `rst_n` is low. Changes to them after reset release have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_boot_pages | input | PW | Boot tier size in flash pages |
| cfg_sec_pages | input | PW | Secure tier size in flash pages |
| cfg_sec_high | input | 1 | Secure tier at high security level |
| cfg_boot_wlock | input | 1 | Forbid all writes to boot flash |
| cfg_boot_entry | input | 1 | Allow entry jumps into boot flash |
| cfg_sec_entry | input | 1 | Allow entry jumps into secure flash |
| cfg_bdat_lo | input | PW | First data page of boot data window |
| cfg_bdat_hi | input | PW | Data page one past the boot data window |
| cfg_sdat_lo | input | PW | First data page of secure data window |
| cfg_sdat_hi | input | PW | Data page one past the secure data window |
| fetch_pc | input | AW | Fetch address of the requesting instruction |
| req_vld | input | 1 | Request valid |
| req_data | input | 1 | 1 = data space, 0 = flash |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 jump |
| req_addr | input | AW | Request address |
| mem_rdata | input | DW | Read data from memory, one cycle after request |
| viol_clr | input | 1 | Clear pulse for the violation record |
| req_gnt | output | 1 | Request granted |
| mem_re | output | 1 | Read strobe to memory |
| mem_we | output | 1 | Write/erase strobe to memory |
| cpu_rdata | output | DW | Read data returned to the processor |
| viol | output | 1 | Sticky violation flag |
| viol_src | output | 2 | Source tier of the recorded violation |
| viol_acc | output | 2 | Access code of the recorded violation |
| viol_data | output | 1 | Address space of the recorded violation |
| viol_addr | output | AW | Address of the recorded violation |

## Verification
The embedded assertions check the following on every cycle: the boot write lock, unconditional grants to general flash, read-data zeroing after a denied read, the set and hold behaviour of the violation record, and that configuration stays frozen after reset. Only the bench scenarios can show the complete policy table. They sweep every source, target, space and access code at tier edges under both security levels, and also cover set-wins-over-clear ordering and that post-reset configuration changes are ignored.

// File: rtl/seg_guard_pkg.sv
// Shared encodings for the segment access guard.
package seg_guard_pkg;
    // Privilege tiers; numeric order follows privilege.
    typedef enum logic [1:0] {
        SEG_GEN  = 2'd0,
        SEG_SEC  = 2'd1,
        SEG_BOOT = 2'd2
    } seg_e;

    // Request kinds presented on req_acc.
    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_JMP = 2'd2,
        ACC_BAD = 2'd3
    } acc_e;
endpackage

// File: rtl/seg_guard_cfg.sv
// Configuration capture: samples every configuration input while reset is
// low and holds the values afterwards. Assumes rst_n is synchronous.
module seg_guard_cfg #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] i_boot_pages,
    input  logic [PW-1:0] i_sec_pages,
    input  logic          i_sec_high,
    input  logic          i_boot_wlock,
    input  logic          i_boot_entry,
    input  logic          i_sec_entry,
    input  logic [PW-1:0] i_bdat_lo,
    input  logic [PW-1:0] i_bdat_hi,
    input  logic [PW-1:0] i_sdat_lo,
    input  logic [PW-1:0] i_sdat_hi,
    output logic [PW-1:0] boot_pages,
    output logic [PW-1:0] sec_pages,
    output logic          sec_high,
    output logic          boot_wlock,
    output logic          boot_entry,
    output logic          sec_entry,
    output logic [PW-1:0] bdat_lo,
    output logic [PW-1:0] bdat_hi,
    output logic [PW-1:0] sdat_lo,
    output logic [PW-1:0] sdat_hi
);
    // Load configuration during reset, freeze it once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_pages <= i_boot_pages;
            sec_pages  <= i_sec_pages;
            sec_high   <= i_sec_high;
            boot_wlock <= i_boot_wlock;
            boot_entry <= i_boot_entry;
            sec_entry  <= i_sec_entry;
            bdat_lo    <= i_bdat_lo;
            bdat_hi    <= i_bdat_hi;
            sdat_lo    <= i_sdat_lo;
            sdat_hi    <= i_sdat_hi;
        end
    end

    // R12: nothing changes while out of reset
    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(boot_pages) && $stable(sec_pages) && $stable(sec_high)
                          && $stable(boot_wlock) && $stable(boot_entry) && $stable(sec_entry)
                          && $stable(bdat_lo) && $stable(bdat_hi)
                          && $stable(sdat_lo) && $stable(sdat_hi)));
endmodule

// File: rtl/seg_guard_map.sv
// Page classifier: maps a page number to a tier. Flash tiers are laid out
// boot first, then secure, then general; data windows are half-open page
// ranges with boot taking precedence over secure where they overlap.
module seg_guard_map
    import seg_guard_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [PW-1:0] page,
    input  logic          is_data,
    input  logic [PW-1:0] boot_pages,
    input  logic [PW-1:0] sec_pages,
    input  logic [PW-1:0] bdat_lo,
    input  logic [PW-1:0] bdat_hi,
    input  logic [PW-1:0] sdat_lo,
    input  logic [PW-1:0] sdat_hi,
    output seg_e          seg
);
    localparam int EW = PW + 1;

    logic [EW-1:0] boot_end;
    logic [EW-1:0] sec_end;
    logic [EW-1:0] page_x;
    logic          in_bdat;
    logic          in_sdat;

    // Flash tier limits; one extra bit keeps the sum from wrapping.
    always_comb begin
        page_x   = {1'b0, page};
        boot_end = {1'b0, boot_pages};
        sec_end  = boot_end + {1'b0, sec_pages};
        in_bdat  = (page >= bdat_lo) && (page < bdat_hi);
        in_sdat  = (page >= sdat_lo) && (page < sdat_hi);
    end

    // Pick the tier for the selected address space.
    always_comb begin
        if (is_data) begin
            if (in_bdat)      seg = SEG_BOOT;
            else if (in_sdat) seg = SEG_SEC;
            else              seg = SEG_GEN;
        end else begin
            if (page_x < boot_end)     seg = SEG_BOOT;
            else if (page_x < sec_end) seg = SEG_SEC;
            else                       seg = SEG_GEN;
        end
    end
endmodule

// File: rtl/seg_guard_rules.sv
// Policy table: decides whether a source tier may perform an access kind on
// a target tier. Purely combinational; assumes tiers come from seg_guard_map.
module seg_guard_rules
    import seg_guard_pkg::*;
(
    input  seg_e  src,
    input  seg_e  tgt,
    input  logic  is_data,
    input  acc_e  acc,
    input  logic  sec_high,
    input  logic  boot_wlock,
    input  logic  boot_entry,
    input  logic  sec_entry,
    output logic  allow
);
    logic is_jmp;
    logic tgt_entry;

    // Helpers shared by the table below.
    always_comb begin
        is_jmp    = (acc == ACC_JMP);
        tgt_entry = (tgt == SEG_BOOT) ? boot_entry : sec_entry;
    end

    // Ordered decision: hard denials first, then tier relations.
    always_comb begin
        allow = 1'b0;
        if (acc == ACC_BAD) begin
            allow = 1'b0;
        end else if (is_data && is_jmp) begin
            allow = 1'b0;
        end else if (!is_data && tgt == SEG_BOOT && acc == ACC_WR && boot_wlock) begin
            allow = 1'b0;
        end else if (tgt == SEG_GEN || src == tgt) begin
            allow = 1'b1;
        end else begin
            unique case (src)
                SEG_BOOT: allow = !sec_high || (is_jmp && sec_entry);
                SEG_SEC:  allow = sec_high || (is_jmp && boot_entry);
                default:  allow = is_jmp && tgt_entry;
            endcase
        end
    end
endmodule

// File: rtl/seg_guard_log.sv
// Violation record: captures the first denied request and holds it until a
// clear pulse; a denial in the clearing cycle is recorded instead.
module seg_guard_log
    import seg_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_vld,
    input  logic          deny,
    input  seg_e          src,
    input  logic [1:0]    acc,
    input  logic          is_data,
    input  logic [AW-1:0] addr,
    input  logic          clr,
    output logic          viol,
    output logic [1:0]    viol_src,
    output logic [1:0]    viol_acc,
    output logic          viol_data,
    output logic [AW-1:0] viol_addr
);
    logic take;

    // A new record is taken when the slot is free or being cleared.
    always_comb take = req_vld && deny && (!viol || clr);

    // Sticky flag and captured fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol      <= 1'b0;
            viol_src  <= '0;
            viol_acc  <= '0;
            viol_data <= 1'b0;
            viol_addr <= '0;
        end else if (take) begin
            viol      <= 1'b1;
            viol_src  <= src;
            viol_acc  <= acc;
            viol_data <= is_data;
            viol_addr <= addr;
        end else if (clr) begin
            viol      <= 1'b0;
        end
    end

    // R11: a denial always leaves the flag set
    a_r11_deny_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && deny) |=> viol);
    // R11: record holds while not cleared
    a_r11_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !clr) |=> (viol && $stable(viol_addr) && $stable(viol_src)));
endmodule

// File: rtl/seg_guard.sv
// Top of the segment access guard: classifies source and target tiers,
// applies the policy, gates memory strobes and read data, and logs denials.
// Assumes memory returns read data one cycle after mem_re.
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int AW = 16,
    parameter int PB = 8,
    parameter int DW = 16,
    parameter int PW = AW - PB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_boot_pages,
    input  logic [PW-1:0] cfg_sec_pages,
    input  logic          cfg_sec_high,
    input  logic          cfg_boot_wlock,
    input  logic          cfg_boot_entry,
    input  logic          cfg_sec_entry,
    input  logic [PW-1:0] cfg_bdat_lo,
    input  logic [PW-1:0] cfg_bdat_hi,
    input  logic [PW-1:0] cfg_sdat_lo,
    input  logic [PW-1:0] cfg_sdat_hi,
    input  logic [AW-1:0] fetch_pc,
    input  logic          req_vld,
    input  logic          req_data,
    input  logic [1:0]    req_acc,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          viol_clr,
    output logic          req_gnt,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] cpu_rdata,
    output logic          viol,
    output logic [1:0]    viol_src,
    output logic [1:0]    viol_acc,
    output logic          viol_data,
    output logic [AW-1:0] viol_addr
);
    logic [PW-1:0] boot_pages, sec_pages, bdat_lo, bdat_hi, sdat_lo, sdat_hi;
    logic          sec_high, boot_wlock, boot_entry, sec_entry;
    seg_e          src_seg, tgt_seg;
    acc_e          acc;
    logic          allow;
    logic          rd_ok_q;

    always_comb acc = acc_e'(req_acc);

    seg_guard_cfg #(.PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .i_boot_pages(cfg_boot_pages), .i_sec_pages(cfg_sec_pages),
        .i_sec_high(cfg_sec_high), .i_boot_wlock(cfg_boot_wlock),
        .i_boot_entry(cfg_boot_entry), .i_sec_entry(cfg_sec_entry),
        .i_bdat_lo(cfg_bdat_lo), .i_bdat_hi(cfg_bdat_hi),
        .i_sdat_lo(cfg_sdat_lo), .i_sdat_hi(cfg_sdat_hi),
        .boot_pages(boot_pages), .sec_pages(sec_pages),
        .sec_high(sec_high), .boot_wlock(boot_wlock),
        .boot_entry(boot_entry), .sec_entry(sec_entry),
        .bdat_lo(bdat_lo), .bdat_hi(bdat_hi),
        .sdat_lo(sdat_lo), .sdat_hi(sdat_hi)
    );

    // Source tier comes from the fetch address, always in flash.
    seg_guard_map #(.PW(PW)) u_src_map (
        .page(fetch_pc[AW-1:PB]), .is_data(1'b0),
        .boot_pages(boot_pages), .sec_pages(sec_pages),
        .bdat_lo(bdat_lo), .bdat_hi(bdat_hi),
        .sdat_lo(sdat_lo), .sdat_hi(sdat_hi),
        .seg(src_seg)
    );

    // Target tier comes from the request address in its space.
    seg_guard_map #(.PW(PW)) u_tgt_map (
        .page(req_addr[AW-1:PB]), .is_data(req_data),
        .boot_pages(boot_pages), .sec_pages(sec_pages),
        .bdat_lo(bdat_lo), .bdat_hi(bdat_hi),
        .sdat_lo(sdat_lo), .sdat_hi(sdat_hi),
        .seg(tgt_seg)
    );

    seg_guard_rules u_rules (
        .src(src_seg), .tgt(tgt_seg), .is_data(req_data), .acc(acc),
        .sec_high(sec_high), .boot_wlock(boot_wlock),
        .boot_entry(boot_entry), .sec_entry(sec_entry),
        .allow(allow)
    );

    seg_guard_log #(.AW(AW)) u_log (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .deny(!allow), .src(src_seg), .acc(req_acc),
        .is_data(req_data), .addr(req_addr), .clr(viol_clr),
        .viol(viol), .viol_src(viol_src), .viol_acc(viol_acc),
        .viol_data(viol_data), .viol_addr(viol_addr)
    );

    // Memory strobes qualified by the policy decision.
    always_comb begin
        req_gnt = req_vld && allow;
        mem_re  = req_gnt && (acc == ACC_RD);
        mem_we  = req_gnt && (acc == ACC_WR);
    end

    // Remember whether the data arriving next cycle may be returned.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_ok_q <= 1'b0;
        else        rd_ok_q <= mem_re;
    end

    // Zero read data for denied or absent reads.
    always_comb cpu_rdata = rd_ok_q ? mem_rdata : '0;

    // R5: locked boot flash never sees a write strobe
    a_r5_boot_wlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_data && boot_wlock && (req_addr[AW-1:PB] < boot_pages)) |-> !mem_we);
    // R2: general flash is open to every valid access code
    a_r2_general_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_data && req_acc != 2'd3
         && ({1'b0, req_addr[AW-1:PB]} >= ({1'b0, boot_pages} + {1'b0, sec_pages})))
        |-> req_gnt);
    // R10: a denied read yields zero data next cycle
    a_r10_denied_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_vld && req_acc == 2'd0 && !req_gnt) |-> (cpu_rdata == '0));
endmodule

// File: tb/seg_guard_bench.sv
// Scoreboard bench for seg_guard: driver pushes expected outcomes, monitor
// compares them one cycle later; violation record checked directly.
module seg_guard_bench;
    localparam int AW = 16, PB = 8, DW = 16, PW = AW - PB;
    localparam logic [DW-1:0] RDAT = 16'hA5C3;

    logic clk = 0, rst_n = 0;
    logic [PW-1:0] cfg_boot_pages, cfg_sec_pages, cfg_bdat_lo, cfg_bdat_hi, cfg_sdat_lo, cfg_sdat_hi;
    logic cfg_sec_high, cfg_boot_wlock, cfg_boot_entry, cfg_sec_entry;
    logic [AW-1:0] fetch_pc = '0, req_addr = '0;
    logic req_vld = 0, req_data = 0, viol_clr = 0;
    logic [1:0] req_acc = '0;
    logic req_gnt, mem_re, mem_we, viol, viol_data;
    logic [DW-1:0] cpu_rdata;
    logic [1:0] viol_src, viol_acc;
    logic [AW-1:0] viol_addr;

    int n_chk = 0, n_err = 0;
    bit m_high, m_wlock, m_bent, m_sent;

    typedef struct { logic gnt; logic re; logic we; logic [DW-1:0] rd; string tag; } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    seg_guard #(.AW(AW), .PB(PB), .DW(DW)) u_seg_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_boot_pages(cfg_boot_pages), .cfg_sec_pages(cfg_sec_pages),
        .cfg_sec_high(cfg_sec_high), .cfg_boot_wlock(cfg_boot_wlock),
        .cfg_boot_entry(cfg_boot_entry), .cfg_sec_entry(cfg_sec_entry),
        .cfg_bdat_lo(cfg_bdat_lo), .cfg_bdat_hi(cfg_bdat_hi),
        .cfg_sdat_lo(cfg_sdat_lo), .cfg_sdat_hi(cfg_sdat_hi),
        .fetch_pc(fetch_pc), .req_vld(req_vld), .req_data(req_data),
        .req_acc(req_acc), .req_addr(req_addr), .mem_rdata(RDAT),
        .viol_clr(viol_clr), .req_gnt(req_gnt), .mem_re(mem_re), .mem_we(mem_we),
        .cpu_rdata(cpu_rdata), .viol(viol), .viol_src(viol_src),
        .viol_acc(viol_acc), .viol_data(viol_data), .viol_addr(viol_addr)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Tier model per R1/R9: boot pages 0..3, secure 4..11; data boot 0x10..0x11, secure 0x12..0x15.
    function automatic int tier(logic [AW-1:0] a, bit d);
        int p = int'(a[AW-1:PB]);
        if (d) return (p >= 'h10 && p < 'h12) ? 2 : (p >= 'h12 && p < 'h16) ? 1 : 0;
        return (p < 4) ? 2 : (p < 12) ? 1 : 0;
    endfunction

    // Policy model from R2..R9; tag names the deciding requirement.
    function automatic bit model(logic [AW-1:0] pc, bit d, int a, logic [AW-1:0] ad, output string tag);
        int s = tier(pc, 0), t = tier(ad, d);
        bit j = (a == 2);
        if (a == 3)                          begin tag = "R9 bad code"; return 0; end
        if (d && j)                          begin tag = "R9 data jump"; return 0; end
        if (!d && t == 2 && a == 1 && m_wlock) begin tag = "R5 boot wlock"; return 0; end
        if (t == 0)                          begin tag = "R2 general target"; return 1; end
        if (s == t)                          begin tag = "R3 own tier"; return 1; end
        if (s == 2) begin
            if (!m_high) begin tag = "R4 boot to secure std"; return 1; end
            tag = "R6 boot to secure high"; return j && m_sent;
        end
        if (s == 1) begin tag = "R7 secure to boot"; return m_high || (j && m_bent); end
        tag = "R8 general entry";
        return j && (t == 2 ? m_bent : m_sent);
    endfunction

    // Driver: present one request at a falling edge and queue its outcome.
    task automatic issue(logic [AW-1:0] pc, bit d, int a, logic [AW-1:0] ad);
        item_t it;
        string tg;
        bit g;
        @(negedge clk);
        fetch_pc = pc; req_data = d; req_acc = 2'(a); req_addr = ad; req_vld = 1;
        g = model(pc, d, a, ad, tg);
        it.gnt = g; it.re = g && a == 0; it.we = g && a == 1;
        it.rd = (g && a == 0) ? RDAT : '0;
        it.tag = tg;
        exp_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        req_vld = 0;
    endtask

    // Monitor: strobes settle before the edge, read data right after it.
    always @(posedge clk) begin
        item_t it;
        logic g, r, w;
        g = req_gnt; r = mem_re; w = mem_we;
        #1;
        if (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            check(g == it.gnt, {it.tag, " gnt"}, g, it.gnt);
            check(r == it.re && w == it.we, "R10 strobes", {r, w}, {it.re, it.we});
            check(cpu_rdata == it.rd, "R10 rdata", cpu_rdata, it.rd);
        end
    end

    task automatic apply_cfg(bit hi, bit wl, bit be, bit se);
        @(negedge clk);
        rst_n = 0; req_vld = 0;
        cfg_boot_pages = 8'd4; cfg_sec_pages = 8'd8;
        cfg_bdat_lo = 8'h10; cfg_bdat_hi = 8'h12; cfg_sdat_lo = 8'h12; cfg_sdat_hi = 8'h16;
        cfg_sec_high = hi; cfg_boot_wlock = wl; cfg_boot_entry = be; cfg_sec_entry = se;
        m_high = hi; m_wlock = wl; m_bent = be; m_sent = se;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Full sweep: sources at tier edges, targets at tier edges, both spaces, all codes.
    task automatic sweep();
        logic [AW-1:0] pcs[5] = '{16'h0000, 16'h03FF, 16'h0400, 16'h0BFF, 16'h0C00};
        logic [AW-1:0] fas[5] = '{16'h0010, 16'h03FF, 16'h0400, 16'h0BFF, 16'h0C00};
        logic [AW-1:0] das[5] = '{16'h10AA, 16'h11FF, 16'h1200, 16'h15FF, 16'h1600};
        foreach (pcs[i])
            for (int a = 0; a < 4; a++)
                for (int k = 0; k < 5; k++) begin
                    issue(pcs[i], 0, a, fas[k]);
                    issue(pcs[i], 1, a, das[k]);
                end
        idle();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 60000);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        apply_cfg(0, 0, 1, 0);
        @(negedge clk);
        check(viol == 0 && req_gnt == 0 && cpu_rdata == 0, "R11 reset state", {viol, req_gnt}, 0);

        // R11: first denial captured (general reads boot flash)
        issue(16'h2000, 0, 0, 16'h0010);
        idle();
        check(viol == 1, "R11 set", viol, 1);
        check(viol_addr == 16'h0010 && viol_src == 0 && viol_acc == 0 && viol_data == 0,
              "R11 fields", {viol_src, viol_acc, viol_data, viol_addr}, 16'h0010);
        // R11: a later denial does not overwrite
        issue(16'h2000, 1, 1, 16'h1300);
        idle();
        check(viol_addr == 16'h0010, "R11 hold", viol_addr, 16'h0010);
        // R11: clear pulse
        viol_clr = 1;
        @(negedge clk);
        viol_clr = 0;
        check(viol == 0, "R11 clear", viol, 0);
        // R11: set wins over clear
        issue(16'h2000, 0, 1, 16'h0400);
        viol_clr = 1;
        @(negedge clk);
        viol_clr = 0; req_vld = 0;
        check(viol == 1 && viol_addr == 16'h0400 && viol_acc == 1, "R11 set wins",
              viol_addr, 16'h0400);

        // R12: later config changes ignored (boot writing boot stays granted)
        cfg_boot_wlock = 1; cfg_sec_high = 1; cfg_boot_pages = 8'd0;
        issue(16'h0100, 0, 1, 16'h0200);
        issue(16'h0100, 0, 0, 16'h0800); // R12 with R4 still standard
        idle();

        // R1..R10 standard level, boot entry on, secure entry off
        sweep();
        // R5, R6, R7 high level, boot locked, secure entry on, boot entry off
        apply_cfg(1, 1, 0, 1);
        sweep();
        // R8 entry bits swapped under high level without lock
        apply_cfg(1, 0, 1, 0);
        sweep();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule